// File: doc/BRIEF.md
# External Memory Strobe Bus Controller

This block runs one transfer to external program or data memory for each request from the core. The pins are a multiplexed address/data port, a separate port for the high address byte, and three active-low controls: an address strobe, a data strobe and a read/write line. Each transfer uses a fixed machine cycle of three phases, and each phase lasts one clock. In the address phase the address strobe is low and the port carries the low address byte, so external logic latches the address when the strobe rises. In the data phase the data strobe is low. On a write, the port carries the write data from the moment the data strobe falls. On a read, the port is released and the block samples it on the clock edge that ends the phase, which is also the edge where the data strobe rises. The recovery phase keeps both strobes high and raises a one-clock done pulse together with the read result.

The core presents `req_valid` with a direction, an address and write data. The block takes the request only when it shows `req_ready`, which it does only in the idle state. The pad ring uses the two output enables. When `float_en` is set, both enables drop, so the strobes, the read/write line and both address ports go high-impedance. The machine keeps sequencing internally while the pins float.

States and transitions: `ST_IDLE` goes to `ST_ADDR` on an accepted request. `ST_ADDR` always goes to `ST_DATA`. `ST_DATA` always goes to `ST_RECOV`. `ST_RECOV` always goes back to `ST_IDLE`.

Top module: `ext_bus_ctrl`

## Requirements
- R1: After reset, as_n, ds_n and rw_n are 1, rsp_done is 0, req_ready is 1, rsp_rdata is 0, and ad_oe is 0.
- R2: A request is taken only in a clock where req_ready is 1, and req_ready is 1 only in the idle state. Holding req_valid during a busy cycle starts nothing and does not change the address or data of the running transfer.
- R3: An accepted request produces exactly three busy clocks. Clock 1 has as_n=0 and ds_n=1, clock 2 has as_n=1 and ds_n=0, and clock 3 has both at 1. The block then returns to idle with req_ready=1.
- R4: In clock 1, ad_out equals req_addr[7:0] with ad_oe=1. In all three busy clocks, addr_hi equals req_addr[15:8] as captured at acceptance.
- R5: For a write (req_write=1), rw_n is 0 in all three busy clocks, and in clocks 2 and 3 ad_out equals the captured write data with ad_oe=1.
- R6: For a read (req_write=0), rw_n stays 1, ad_oe is 0 in clocks 2 and 3, and ad_in is sampled on the clock edge that ends clock 2. Values of ad_in at other times have no effect.
- R7: rsp_done is 1 for exactly clock 3 of each transfer, and rsp_rdata then holds the sampled read byte. rsp_rdata keeps its value across writes and idle time.
- R8: bus_oe is the inverse of float_en. While float_en is 1, ad_oe is 0, and sequencing and rsp_done proceed unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| float_en | input | 1 | Float all bus pins |
| req_valid | input | 1 | Transfer request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Transfer address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Idle, request can be taken |
| rsp_done | output | 1 | Transfer finished pulse |
| rsp_rdata | output | 8 | Last read byte |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 1 | Data strobe, active low |
| rw_n | output | 1 | Read high / write low |
| addr_hi | output | 8 | High address byte |
| ad_out | output | 8 | Address/data port output value |
| ad_oe | output | 1 | Address/data port drive enable |
| ad_in | input | 8 | Address/data port input value |
| bus_oe | output | 1 | Drive enable for strobes, rw_n and addr_hi |

## Verification
The bench drives ad_in with a value that changes every clock. If the capture edge were one clock off, rsp_rdata would differ from the byte that was present when the data strobe rose. A request held high across a whole busy cycle with a different address checks that the design neither starts a second cycle nor relatches mid-cycle, which would show up as a changed addr_hi or an extra address strobe. Back-to-back requests, floating in the middle of a transfer, and writes placed between reads check that a single idle clock separates the cycles, that the enables drop without disturbing the sequence, and that writes leave rsp_rdata untouched.

// File: rtl/ext_bus_pkg.sv
package ext_bus_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ADDR  = 2'd1,
        ST_DATA  = 2'd2,
        ST_RECOV = 2'd3
    } bus_state_e;
endpackage

// File: rtl/ext_bus_fsm.sv
module ext_bus_fsm
    import ext_bus_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output bus_state_e state,
    output logic       as_n,
    output logic       ds_n,
    output logic       done,
    output logic       ready
);
    bus_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_ADDR;
            ST_ADDR:  state_nx = ST_DATA;
            ST_DATA:  state_nx = ST_RECOV;
            ST_RECOV: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        as_n  = 1'b1;
        ds_n  = 1'b1;
        done  = 1'b0;
        ready = 1'b0;
        unique case (state)
            ST_IDLE:  ready = 1'b1;
            ST_ADDR:  as_n  = 1'b0;
            ST_DATA:  ds_n  = 1'b0;
            ST_RECOV: done  = 1'b1;
            default:  ready = 1'b0;
        endcase
    end

    // R3: the data strobe follows the address strobe in the next clock
    a_r3_ds_after_as: assert property (@(posedge clk) disable iff (!rst_n)
        !as_n |=> !ds_n);
    // R3, R7: recovery after the data strobe, done only there
    a_r7_done_after_ds: assert property (@(posedge clk) disable iff (!rst_n)
        !ds_n |=> (as_n && ds_n && done));
    // R3: back to idle after done
    a_r3_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ready);
    // R2: a start leads into the address phase
    a_r2_start_to_as: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !as_n);
endmodule

// File: rtl/ext_bus_dp.sv
module ext_bus_dp
    import ext_bus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_state_e        state,
    input  logic              accept,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] ad_in,
    output logic              rw_n,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_drive,
    output logic [DATA_W-1:0] rdata
);
    localparam int HI_W = ADDR_W - DATA_W;

    logic              cur_write;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_write <= 1'b0;
            cur_addr  <= '0;
            cur_wdata <= '0;
        end else if (accept) begin
            cur_write <= req_write;
            cur_addr  <= req_addr;
            cur_wdata <= req_wdata;
        end
    end

    // read byte sampled at the edge that ends the data phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               rdata <= '0;
        else if (state == ST_DATA && !cur_write)  rdata <= ad_in;
    end

    always_comb begin
        rw_n     = 1'b1;
        ad_out   = cur_wdata;
        ad_drive = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_ADDR: begin
                rw_n     = !cur_write;
                ad_out   = cur_addr[DATA_W-1:0];
                ad_drive = 1'b1;
            end
            ST_DATA, ST_RECOV: begin
                rw_n     = !cur_write;
                ad_drive = cur_write;
            end
            default: ;
        endcase
    end

    assign addr_hi = cur_addr[ADDR_W-1:DATA_W];

    // R4: high address byte held through data and recovery phases
    a_r4_hi_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA || state == ST_RECOV) |-> $stable(addr_hi));
    // R5: direction held across a busy cycle
    a_r5_rw_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(rw_n));
    // R6: port driven in data phases only for writes
    a_r6_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        ad_drive |-> (state == ST_ADDR || !rw_n));
    // R7: read byte changes only as done appears
    a_r7_rdata_moves_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata) |-> state == ST_RECOV);
    initial begin
        assert (HI_W > 0) else $error("address must be wider than data");
    end
endmodule

// File: rtl/ext_bus_pad.sv
module ext_bus_pad (
    input  logic float_en,
    input  logic ad_drive,
    output logic ad_oe,
    output logic bus_oe
);
    assign bus_oe = !float_en;
    assign ad_oe  = ad_drive && !float_en;
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
    import ext_bus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              float_en,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              as_n,
    output logic              ds_n,
    output logic              rw_n,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] ad_in,
    output logic              bus_oe
);
    bus_state_e state;
    logic       accept;
    logic       ad_drive;

    assign accept = req_valid && req_ready;

    ext_bus_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .state (state),
        .as_n  (as_n),
        .ds_n  (ds_n),
        .done  (rsp_done),
        .ready (req_ready)
    );

    ext_bus_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .accept    (accept),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ad_in     (ad_in),
        .rw_n      (rw_n),
        .addr_hi   (addr_hi),
        .ad_out    (ad_out),
        .ad_drive  (ad_drive),
        .rdata     (rsp_rdata)
    );

    ext_bus_pad u_pad (
        .float_en (float_en),
        .ad_drive (ad_drive),
        .ad_oe    (ad_oe),
        .bus_oe   (bus_oe)
    );

    // R8: floating pins never drive the port
    a_r8_float_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        float_en |-> (!ad_oe && !bus_oe));
    // R2: busy means not ready
    a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_n || !ds_n || rsp_done) |-> !req_ready);
endmodule

// File: tb/test_ext_bus_ctrl.sv
`timescale 1ns/100ps
module test_ext_bus_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        float_en = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  ad_in = 8'h11;
    logic        req_ready, rsp_done, as_n, ds_n, rw_n, ad_oe, bus_oe;
    logic [7:0]  rsp_rdata, addr_hi, ad_out;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    ext_bus_ctrl i_ext_bus_ctrl (
        .clk(clk), .rst_n(rst_n), .float_en(float_en),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .rsp_done(rsp_done),
        .rsp_rdata(rsp_rdata), .as_n(as_n), .ds_n(ds_n), .rw_n(rw_n),
        .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
        .bus_oe(bus_oe)
    );

    // behavioural reference: phase 0 idle, 1 address, 2 data, 3 recovery
    int          m_phase = 0;
    bit          m_write = 0;
    logic [15:0] m_addr = '0;
    logic [7:0]  m_wdata = '0;
    logic [7:0]  m_rdata = '0;
    int          n_cycles = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase <= 0; m_rdata <= '0;
        end else begin
            case (m_phase)
                0: if (req_valid) begin
                       m_phase <= 1; m_write <= req_write;
                       m_addr <= req_addr; m_wdata <= req_wdata;
                       n_cycles <= n_cycles + 1;
                   end
                1: m_phase <= 2;
                2: begin
                       if (!m_write) m_rdata <= ad_in;
                       m_phase <= 3;
                   end
                default: m_phase <= 0;
            endcase
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // compare every clock, away from the edges
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            bit e_oe;
            e_oe = !float_en && (m_phase == 1 || (m_write && m_phase >= 2));
            chk(as_n == (m_phase != 1), "R3", "as_n", as_n, m_phase != 1);
            chk(ds_n == (m_phase != 2), "R3", "ds_n", ds_n, m_phase != 2);
            chk(req_ready == (m_phase == 0), "R2", "req_ready", req_ready, m_phase == 0);
            chk(rsp_done == (m_phase == 3), "R7", "rsp_done", rsp_done, m_phase == 3);
            chk(rsp_rdata == m_rdata, "R7", "rsp_rdata", rsp_rdata, m_rdata);
            chk(rw_n == !(m_phase != 0 && m_write), "R5", "rw_n", rw_n, !(m_phase != 0 && m_write));
            chk(bus_oe == !float_en, "R8", "bus_oe", bus_oe, !float_en);
            chk(ad_oe == e_oe, "R6", "ad_oe", ad_oe, e_oe);
            if (m_phase != 0)
                chk(addr_hi == m_addr[15:8], "R4", "addr_hi", addr_hi, m_addr[15:8]);
            if (m_phase == 1)
                chk(ad_out == m_addr[7:0], "R4", "ad_out addr", ad_out, m_addr[7:0]);
            if (m_write && m_phase >= 2)
                chk(ad_out == m_wdata, "R5", "ad_out data", ad_out, m_wdata);
        end
    end

    // port input changes every clock so the capture edge matters (R6)
    always @(negedge clk) ad_in <= ad_in + 8'h35;

    task automatic xfer(input bit wr, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_addr = 16'hDEAD; req_wdata = 8'hEE;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(as_n && ds_n && rw_n, "R1", "strobes", {as_n, ds_n, rw_n}, 3'b111);
        chk(!rsp_done && req_ready, "R1", "done/ready", {rsp_done, req_ready}, 2'b01);
        chk(rsp_rdata == 8'h00 && !ad_oe, "R1", "rdata/ad_oe", rsp_rdata, 0);
        rst_n = 1'b1;
        xfer(1'b1, 16'h12A5, 8'h3C);
        xfer(1'b0, 16'hBEEF, 8'h00);
        xfer(1'b0, 16'h0001, 8'h00);
        xfer(1'b1, 16'hFF00, 8'hC3);   // R7: write keeps last read byte
        repeat (4) @(negedge clk);
        // R2: request held through a whole busy cycle with a new address
        req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h4321;
        @(negedge clk);
        req_addr = 16'h9999; req_write = 1'b1;
        repeat (3) @(negedge clk);     // now idle: drop it first
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(n_cycles == 5, "R2", "cycle count", n_cycles, 5);
        // R3: back-to-back requests, one idle clock between cycles
        req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h5A5A;
        repeat (12) @(negedge clk);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        // R8: float raised mid transfer, then dropped
        xfer(1'b1, 16'h7E81, 8'h99);
        float_en = 1'b1;
        repeat (2) @(negedge clk);
        xfer(1'b0, 16'hA0A0, 8'h00);
        repeat (4) @(negedge clk);
        float_en = 1'b0;
        xfer(1'b1, 16'h0F0F, 8'h55);
        repeat (6) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule